// File: doc/BRIEF.md
# Chaotic Sample ASCII Serializer

This block sits between a generator of signed fixed-point chaotic samples and a byte-wide UART transmitter. It turns each sample into a row of printable ASCII decimal characters that a host can read as plain text. Before conversion, a constant offset is added to the sample so that the emitted number is never negative. The sum is then split into an integer part and a binary fraction.

The integer part goes through a serial shift-and-add-3 converter and comes out as a fixed number of decimal digits, zero-padded on the left. The fraction is expanded one decimal digit at a time: it is multiplied by ten and the part that crosses the binary point is taken as the digit. The most significant digit is sent first. No decimal point is sent, because the host knows how many fraction digits each value carries. A comma closes every value.

The sample side and the character side are both valid/ready ports. A new sample is taken only once the previous value, comma included, has left the block. While the UART holds its ready low, the character port waits without dropping or changing a byte.

Top module: `chaos_ascii_serializer`

## Requirements
- R1: The converted quantity is the sample (two's complement, FRAC_BITS fraction bits) plus the parameter OFFSET in the same raw units. If that sum is negative, the value zero is emitted instead.
- R2: Exactly INT_DIGITS integer digits are sent, most significant first, with zero padding on the left. Each digit d is sent as the byte 0x30 + d.
- R3: Exactly FRAC_DIGITS fraction digits follow the integer digits. They are the truncated decimal expansion of the binary fraction, sent as 0x30 + d, and no decimal-point byte is ever sent.
- R4: Every value ends with one comma byte 0x2C, so each value is INT_DIGITS + FRAC_DIGITS + 1 bytes long and no other bytes appear.
- R5: smp_ready is high exactly when no part of an earlier value, comma included, remains to be sent. A sample is taken only on a cycle where smp_valid and smp_ready are both high.
- R6: While chr_valid is high and chr_ready is low, chr_valid stays high and chr_data keeps its value on the next cycle.
- R7: After synchronous reset, smp_ready is high and chr_valid is low.
- R8: Whenever chr_valid is high, chr_data is one of the ASCII digits 0x30 to 0x39 or the comma 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is offered |
| smp_ready | output | 1 | The block can take a sample |
| smp_data | input | SAMPLE_W | Signed fixed-point sample |
| chr_valid | output | 1 | An ASCII byte is offered |
| chr_ready | input | 1 | The UART can take the byte |
| chr_data | output | 8 | ASCII byte |

## Verification
On every cycle, the assertions check four things:
- a stalled byte is held unchanged;
- only digit and comma codes appear;
- the two ports are never active at once;
- the sample port reopens right after a comma has been taken.

Only the bench's scenarios can show that the digits are numerically right: the offset, the clamp at zero, the zero padding, the truncated fraction, and the byte count per value. To show this, the bench compares the stream against a model that does integer arithmetic. It does so across these cases:
- directed extreme samples;
- random samples;
- random downstream back-pressure;
- a long stall.

// File: rtl/chaos_ascii_pkg.sv
package chaos_ascii_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_INT,
        ST_FRAC,
        ST_SEP
    } ser_state_e;

    localparam logic [7:0] ASCII_ZERO  = 8'h30;
    localparam logic [7:0] ASCII_NINE  = 8'h39;
    localparam logic [7:0] ASCII_COMMA = 8'h2C;

    function automatic logic [7:0] digit_to_ascii(input logic [3:0] d);
        return ASCII_ZERO + {4'h0, d};
    endfunction

    function automatic logic is_emit_byte(input logic [7:0] b);
        return ((b >= ASCII_ZERO) && (b <= ASCII_NINE)) || (b == ASCII_COMMA);
    endfunction

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cas_offset_split.sv
module cas_offset_split #(
    parameter int          SAMPLE_W  = 16,
    parameter int          FRAC_BITS = 8,
    parameter int unsigned OFFSET    = 32768,
    localparam int         MAG_W     = SAMPLE_W + 1,
    localparam int         INT_W     = MAG_W - FRAC_BITS
) (
    input  logic [SAMPLE_W-1:0]  sample,
    output logic [INT_W-1:0]     int_part,
    output logic [FRAC_BITS-1:0] frac_part
);
    localparam logic [SAMPLE_W-1:0] OFS = OFFSET[SAMPLE_W-1:0];

    logic signed [SAMPLE_W+1:0] sum;
    logic        [MAG_W-1:0]    mag;

    assign sum = $signed({{2{sample[SAMPLE_W-1]}}, sample}) + $signed({2'b00, OFS});
    // Clamp a negative sum to zero (R1).
    assign mag       = sum[SAMPLE_W+1] ? '0 : sum[MAG_W-1:0];
    assign int_part  = mag[MAG_W-1:FRAC_BITS];
    assign frac_part = mag[FRAC_BITS-1:0];

    always_comb begin
        assert (!(sum < 0) || (int_part == '0 && frac_part == '0))
            else $error("p_clamp_zero_r1");
    end
endmodule

// File: rtl/cas_bcd_conv.sv
module cas_bcd_conv #(
    parameter int BIN_W  = 9,
    parameter int DIGITS = 3,
    localparam int BCD_W = 4 * DIGITS,
    localparam int CNT_W = $clog2(BIN_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BIN_W-1:0] bin,
    output logic             busy,
    output logic             done,
    output logic [BCD_W-1:0] bcd
);
    logic [BIN_W-1:0] sh;
    logic [CNT_W-1:0] cnt;
    logic [BCD_W-1:0] adj;

    for (genvar g = 0; g < DIGITS; g++) begin : g_adj
        always_comb begin
            if (bcd[g*4 +: 4] >= 4'd5)
                adj[g*4 +: 4] = bcd[g*4 +: 4] + 4'd3;
            else
                adj[g*4 +: 4] = bcd[g*4 +: 4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            bcd  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh   <= bin;
                bcd  <= '0;
                cnt  <= CNT_W'(BIN_W);
                busy <= 1'b1;
            end else if (busy) begin
                bcd <= {adj[BCD_W-2:0], sh[BIN_W-1]};
                sh  <= {sh[BIN_W-2:0], 1'b0};
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Every digit of a finished conversion must be a decimal digit (R2).
    always_comb begin
        if (done) begin
            for (int k = 0; k < DIGITS; k++) begin
                assert (bcd[k*4 +: 4] <= 4'd9) else $error("p_bcd_nibble_r2");
            end
        end
    end

    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy) && !busy);
endmodule

// File: rtl/cas_frac_digits.sv
module cas_frac_digits #(
    parameter int FRAC_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [FRAC_BITS-1:0] frac_in,
    input  logic                 step,
    output logic [3:0]           digit
);
    logic [FRAC_BITS-1:0] rem;
    logic [FRAC_BITS+3:0] prod;

    assign prod  = {4'h0, rem} * (FRAC_BITS + 4)'(10);
    assign digit = prod[FRAC_BITS+3:FRAC_BITS];

    always_ff @(posedge clk) begin
        if (rst)
            rem <= '0;
        else if (load)
            rem <= frac_in;
        else if (step)
            rem <= prod[FRAC_BITS-1:0];
    end

    p_frac_digit_r3: assert property (@(posedge clk) disable iff (rst)
        digit <= 4'd9);
endmodule

// File: rtl/chaos_ascii_serializer.sv
module chaos_ascii_serializer
    import chaos_ascii_pkg::*;
#(
    parameter int          SAMPLE_W    = 16,
    parameter int          FRAC_BITS   = 8,
    parameter int unsigned OFFSET      = 32768,
    parameter int          INT_DIGITS  = 3,
    parameter int          FRAC_DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                chr_valid,
    input  logic                chr_ready,
    output logic [7:0]          chr_data
);
    localparam int INT_W  = SAMPLE_W + 1 - FRAC_BITS;
    localparam int BCD_W  = 4 * INT_DIGITS;
    localparam int IDX_W  = cnt_width(INT_DIGITS);
    localparam int FCNT_W = cnt_width(FRAC_DIGITS);

    ser_state_e           state;
    logic [IDX_W-1:0]     dig_idx;
    logic [FCNT_W-1:0]    fcnt;
    logic [INT_W-1:0]     int_part;
    logic [FRAC_BITS-1:0] frac_part;
    logic                 accept;
    logic                 bcd_busy;
    logic                 bcd_done;
    logic [BCD_W-1:0]     bcd_val;
    logic [3:0]           frac_dig;
    logic [3:0]           bcd_nib [INT_DIGITS];
    logic [3:0]           int_dig;

    assign smp_ready = (state == ST_IDLE);
    assign accept    = smp_valid && smp_ready;

    cas_offset_split #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_BITS(FRAC_BITS),
        .OFFSET   (OFFSET)
    ) u_split (
        .sample   (smp_data),
        .int_part (int_part),
        .frac_part(frac_part)
    );

    cas_bcd_conv #(
        .BIN_W (INT_W),
        .DIGITS(INT_DIGITS)
    ) u_bcd (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .bin  (int_part),
        .busy (bcd_busy),
        .done (bcd_done),
        .bcd  (bcd_val)
    );

    cas_frac_digits #(
        .FRAC_BITS(FRAC_BITS)
    ) u_frac (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .frac_in(frac_part),
        .step   ((state == ST_FRAC) && chr_ready),
        .digit  (frac_dig)
    );

    for (genvar g = 0; g < INT_DIGITS; g++) begin : g_nib
        assign bcd_nib[g] = bcd_val[g*4 +: 4];
    end
    assign int_dig = bcd_nib[dig_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dig_idx <= '0;
            fcnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (smp_valid) state <= ST_CONV;
                ST_CONV: if (bcd_done) begin
                    state   <= ST_INT;
                    dig_idx <= IDX_W'(INT_DIGITS - 1);
                end
                ST_INT: if (chr_ready) begin
                    if (dig_idx == '0) begin
                        state <= ST_FRAC;
                        fcnt  <= '0;
                    end else begin
                        dig_idx <= dig_idx - 1'b1;
                    end
                end
                ST_FRAC: if (chr_ready) begin
                    if (fcnt == FCNT_W'(FRAC_DIGITS - 1))
                        state <= ST_SEP;
                    else
                        fcnt <= fcnt + 1'b1;
                end
                ST_SEP:  if (chr_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        chr_valid = 1'b1;
        case (state)
            ST_INT:  chr_data = digit_to_ascii(int_dig);
            ST_FRAC: chr_data = digit_to_ascii(frac_dig);
            ST_SEP:  chr_data = ASCII_COMMA;
            default: begin
                chr_valid = 1'b0;
                chr_data  = ASCII_ZERO;
            end
        endcase
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        chr_valid && !chr_ready |=> chr_valid && $stable(chr_data));

    p_byte_set_r8: assert property (@(posedge clk) disable iff (rst)
        chr_valid |-> is_emit_byte(chr_data));

    p_port_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(smp_ready && chr_valid));

    p_take_closes_r5: assert property (@(posedge clk) disable iff (rst)
        smp_valid && smp_ready |=> !smp_ready);

    p_comma_reopens_r4: assert property (@(posedge clk) disable iff (rst)
        chr_valid && chr_ready && chr_data == ASCII_COMMA |=> smp_ready);

    p_conv_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        bcd_busy |-> !chr_valid);

    p_reset_state_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> smp_ready && !chr_valid);
endmodule

// File: tb/chaos_ascii_serializer_tb.sv
module chaos_ascii_serializer_tb;
    localparam int          SW  = 16;
    localparam int          FB  = 8;
    localparam int unsigned OFS = 16384;
    localparam int          ID  = 3;
    localparam int          FD  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [SW-1:0] smp_data = '0;
    logic          chr_valid;
    logic          chr_ready = 1'b1;
    logic [7:0]    chr_data;

    int         n_cmp  = 0;
    int         n_fail = 0;
    int         ready_mode = 0;
    logic [7:0] exp_q[$];
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic [15:0] rdy_lfsr = 16'hACE1;

    always #10 clk = ~clk;

    chaos_ascii_serializer #(
        .SAMPLE_W   (SW),
        .FRAC_BITS  (FB),
        .OFFSET     (OFS),
        .INT_DIGITS (ID),
        .FRAC_DIGITS(FD)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp_ready(smp_ready),
        .smp_data (smp_data),
        .chr_valid(chr_valid),
        .chr_ready(chr_ready),
        .chr_data (chr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void push_expected(input logic [SW-1:0] s);
        int v;
        int ip;
        int fp;
        int p;
        v = int'($signed(s)) + int'(OFS);
        if (v < 0) v = 0;                       // R1 clamp
        ip = v >> FB;
        fp = v & ((1 << FB) - 1);
        for (int k = ID - 1; k >= 0; k--) begin // R2 padded, MSB first
            p = 1;
            for (int j = 0; j < k; j++) p = p * 10;
            exp_q.push_back(8'(48 + (ip / p) % 10));
        end
        for (int k = 0; k < FD; k++) begin      // R3 truncated fraction
            fp = fp * 10;
            exp_q.push_back(8'(48 + (fp >> FB)));
            fp = fp & ((1 << FB) - 1);
        end
        exp_q.push_back(8'h2C);                 // R4 comma
    endfunction

    // Reference model, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check(smp_ready == (exp_q.size() == 0), "R5 ready", int'(smp_ready),
                  int'(exp_q.size() == 0));
            if (prev_stall)
                check(chr_valid && chr_data == prev_data, "R6 hold", int'(chr_data),
                      int'(prev_data));
            if (chr_valid && !is_ok_byte(chr_data))
                check(1'b0, "R8 byte set", int'(chr_data), 48);
            if (chr_valid && chr_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 extra byte", int'(chr_data), 0);
                end else begin
                    check(chr_data == exp_q[0], "R2/R3/R4 byte", int'(chr_data),
                          int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end
            if (smp_valid && smp_ready) push_expected(smp_data);
            prev_stall = chr_valid && !chr_ready;
            prev_data  = chr_data;
        end
    end

    function automatic bit is_ok_byte(input logic [7:0] b);
        return (b >= 8'h30 && b <= 8'h39) || b == 8'h2C;
    endfunction

    always @(posedge clk) begin
        #1;
        rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
        case (ready_mode)
            0:       chr_ready = 1'b1;
            1:       chr_ready = rdy_lfsr[0];
            default: chr_ready = 1'b0;
        endcase
    end

    task automatic send(input logic [SW-1:0] v);
        smp_data  = v;
        smp_valid = 1'b1;
        do @(negedge clk); while (!smp_ready);
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [SW-1:0] dir [8];
        logic [15:0]   s_lfsr;
        dir = '{16'h0000, 16'h8000, 16'h7FFF, 16'hC000,
                16'hBFFF, 16'h0001, 16'hFFFF, 16'h0180};
        s_lfsr = 16'h1D2B;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R7: idle after reset
        check(smp_ready == 1'b1, "R7 ready", int'(smp_ready), 1);
        check(chr_valid == 1'b0, "R7 valid", int'(chr_valid), 0);

        // Directed values at full downstream speed (R1 clamp, R2, R3, R4)
        for (int i = 0; i < 8; i++) send(dir[i]);
        // Same values with random back-pressure (R6)
        ready_mode = 1;
        for (int i = 0; i < 8; i++) send(dir[i]);
        for (int i = 0; i < 40; i++) begin
            s_lfsr = {s_lfsr[14:0], s_lfsr[15] ^ s_lfsr[13] ^ s_lfsr[12] ^ s_lfsr[10]};
            send(s_lfsr);
        end
        while (exp_q.size() != 0) @(posedge clk);
        // Long stall: bytes must wait unchanged (R6) and no new sample taken (R5)
        ready_mode = 2;
        send(16'h1234);
        smp_data  = 16'h0777;
        smp_valid = 1'b1;
        repeat (40) @(posedge clk);
        ready_mode = 0;
        do @(negedge clk); while (!smp_ready);
        @(posedge clk);
        #1 smp_valid = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule